// File: doc/BRIEF.md
# Fetch Target Queue

This block sits between a branch-prediction stage and a pipelined instruction cache and keeps the two apart. The predictor writes fetch-block descriptors into the queue as fast as it can produce them. The cache reads them out at its own rate, so the predictor can run ahead of the fetch.

A descriptor describes a run of sequential instructions. The run starts at a branch target and stops at a branch that almost always goes the same way. A descriptor holds three things: the start address, the block end as a short offset from that start, and a flag that is set when the block spans more than one cache line. On the cache side the oldest descriptor is always shown. The second-oldest is also shown when it can be sent in the same cycle to a second cache port.

A flush input is raised on a branch misprediction. It throws away every queued descriptor in one cycle. Full and empty outputs tell the predictor to stall and the cache to idle.

Top module: `fetch_target_queue`

## Requirements
- R1: After a synchronous reset, `empty` is 1 and `full`, `out0_valid` and `out1_valid` are all 0.
- R2: Descriptors come out in the order they went in, with the start, offset and flag fields unchanged. `out0_*` shows the oldest entry while `out0_valid` is 1. It holds steady until `take0` is raised.
- R3: `full` is 1 exactly when DEPTH entries are held. A push while full with no pop in the same cycle is dropped, and the stored entries stay as they were.
- R4: `empty` is 1 exactly when no entry is held. While empty, `take0` and `take1` have no effect.
- R5: `out1_valid` is 1 only when at least two entries are held and neither of the two oldest has its oversize flag (bit `out*_over`) set. `out1_*` then shows the second-oldest entry.
- R6: When `out1_valid` is 1, raising `take0` and `take1` together removes the two oldest entries in one cycle.
- R7: When `out1_valid` is 0, `take1` is ignored. `take0` then removes a single entry, so an oversize entry always leaves alone.
- R8: `flush` empties the queue within one cycle. A push and any pops in that same cycle are ignored.
- R9: When the queue is full, a push together with a single pop is accepted. The queue stays full and the new entry goes to the tail.
- R10: When the queue is empty, a push together with `take0` is accepted. The pop is ignored and one entry is held afterwards.
- R11: When the queue is full, a push together with a dual pop leaves DEPTH-1 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all queued descriptors |
| push_valid | input | 1 | Predictor offers a descriptor |
| push_start | input | ADDR_W | Start address of the offered block |
| push_off | input | OFF_W | End offset of the offered block |
| push_over | input | 1 | Offered block is longer than a cache line |
| full | output | 1 | Queue holds DEPTH entries |
| take0 | input | 1 | Cache consumes the oldest entry |
| take1 | input | 1 | Cache also consumes the second-oldest entry |
| out0_valid | output | 1 | Oldest entry present |
| out0_start | output | ADDR_W | Oldest entry start address |
| out0_off | output | OFF_W | Oldest entry end offset |
| out0_over | output | 1 | Oldest entry oversize flag |
| out1_valid | output | 1 | Second-oldest entry may issue with the oldest |
| out1_start | output | ADDR_W | Second-oldest entry start address |
| out1_off | output | OFF_W | Second-oldest entry end offset |
| out1_over | output | 1 | Second-oldest entry oversize flag |
| empty | output | 1 | Queue holds no entry |

## Verification
The bench drives a four-entry queue through several kinds of stimulus:
- Directed fill-and-drain runs tell ordering errors apart from overflow errors.
- Oversize and normal entries are interleaved while the cache always asks for two. This separates a correct pairing decision from one that ignores either flag.
- Pushes combined with single and dual pops at exactly full and at exactly empty expose off-by-one mistakes in the room and pop counts.
- A flush with a simultaneous push shows whether the push leaks through.
- A long pseudo-random sweep over every mix of push, pop, dual pop, oversize and flush is compared each cycle against a queue model built from the requirements.

// File: rtl/ftq_pkg.sv
package ftq_pkg;

    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned DEF_OFF_W  = 4;
    localparam int unsigned DEF_DEPTH  = 8;

    // How many entries the consumer side retires in a cycle.
    typedef enum logic [1:0] {
        POP_NONE = 2'd0,
        POP_ONE  = 2'd1,
        POP_TWO  = 2'd2
    } pop_e;

    function automatic int unsigned pop_count(pop_e sel);
        case (sel)
            POP_ONE: return 1;
            POP_TWO: return 2;
            default: return 0;
        endcase
    endfunction

    // Circular pointer advance for any depth, power of two or not.
    function automatic int unsigned ptr_add(int unsigned p, int unsigned inc,
                                            int unsigned depth);
        int unsigned s;
        s = p + inc;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/fq_store.sv
module fq_store #(
    parameter int unsigned DESC_W = 37,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned PTR_W  = 3
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DESC_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr0,
    input  logic [PTR_W-1:0]  rd_ptr1,
    output logic [DESC_W-1:0] rd_data0,
    output logic [DESC_W-1:0] rd_data1
);
    logic [DEPTH-1:0][DESC_W-1:0] slots;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DESC_W-1:0] ent_q;
        always_ff @(posedge clk) begin
            if (wr_en && wr_ptr == PTR_W'(i)) ent_q <= wr_data;
        end
        assign slots[i] = ent_q;
    end

    assign rd_data0 = slots[rd_ptr0];
    assign rd_data1 = slots[rd_ptr1];
endmodule

// File: rtl/fq_ctrl.sv
module fq_ctrl
    import ftq_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned PTR_W = 3,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push_valid,
    input  logic             take0,
    input  logic             take1,
    input  logic             pair_ok,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr0,
    output logic [PTR_W-1:0] rd_ptr1,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [PTR_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] cnt_q, pop_n, after_pop;
    pop_e             pop_sel;

    always_comb begin
        pop_sel = POP_NONE;
        if (!flush && cnt_q != '0 && take0)
            pop_sel = (take1 && pair_ok) ? POP_TWO : POP_ONE;
    end

    assign pop_n     = CNT_W'(pop_count(pop_sel));
    assign after_pop = cnt_q - pop_n;
    assign wr_en     = push_valid && !flush && (after_pop != CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            head_q <= PTR_W'(ptr_add(32'(head_q), pop_count(pop_sel), DEPTH));
            if (wr_en) tail_q <= PTR_W'(ptr_add(32'(tail_q), 1, DEPTH));
            cnt_q  <= after_pop + CNT_W'(wr_en);
        end
    end

    assign wr_ptr  = tail_q;
    assign rd_ptr0 = head_q;
    assign rd_ptr1 = PTR_W'(ptr_add(32'(head_q), 1, DEPTH));
    assign count   = cnt_q;
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
endmodule

// File: rtl/fq_pair.sv
module fq_pair #(
    parameter int unsigned CNT_W = 4
) (
    input  logic [CNT_W-1:0] count,
    input  logic             over0,
    input  logic             over1,
    output logic             valid0,
    output logic             pair_ok
);
    assign valid0  = (count != '0);
    assign pair_ok = (count >= CNT_W'(2)) && !over0 && !over1;
endmodule

// File: rtl/fetch_target_queue.sv
module fetch_target_queue
    import ftq_pkg::*;
#(
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned OFF_W  = DEF_OFF_W,
    parameter int unsigned DEPTH  = DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push_valid,
    input  logic [ADDR_W-1:0] push_start,
    input  logic [OFF_W-1:0]  push_off,
    input  logic              push_over,
    output logic              full,
    input  logic              take0,
    input  logic              take1,
    output logic              out0_valid,
    output logic [ADDR_W-1:0] out0_start,
    output logic [OFF_W-1:0]  out0_off,
    output logic              out0_over,
    output logic              out1_valid,
    output logic [ADDR_W-1:0] out1_start,
    output logic [OFF_W-1:0]  out1_off,
    output logic              out1_over,
    output logic              empty
);
    localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
    localparam int unsigned DESC_W = ADDR_W + OFF_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [OFF_W-1:0]  off;
        logic              over;
    } desc_t;

    desc_t            wr_desc, rd0, rd1;
    logic             wr_en, pair_ok;
    logic [PTR_W-1:0] wr_ptr, rd_ptr0, rd_ptr1;
    logic [CNT_W-1:0] count;

    assign wr_desc = '{start: push_start, off: push_off, over: push_over};

    fq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .flush(flush), .push_valid(push_valid),
        .take0(take0), .take1(take1), .pair_ok(pair_ok),
        .wr_en(wr_en), .wr_ptr(wr_ptr), .rd_ptr0(rd_ptr0), .rd_ptr1(rd_ptr1),
        .count(count), .full(full), .empty(empty)
    );

    fq_store #(.DESC_W(DESC_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_desc),
        .rd_ptr0(rd_ptr0), .rd_ptr1(rd_ptr1), .rd_data0(rd0), .rd_data1(rd1)
    );

    fq_pair #(.CNT_W(CNT_W)) u_pair (
        .count(count), .over0(rd0.over), .over1(rd1.over),
        .valid0(out0_valid), .pair_ok(pair_ok)
    );

    assign out0_start = rd0.start;
    assign out0_off   = rd0.off;
    assign out0_over  = rd0.over;
    assign out1_valid = pair_ok;
    assign out1_start = rd1.start;
    assign out1_off   = rd1.off;
    assign out1_over  = rd1.over;
endmodule

// File: rtl/fq_checker.sv
module fq_checker #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic              push_valid,
    input logic              take0,
    input logic              take1,
    input logic              full,
    input logic              empty,
    input logic              out0_valid,
    input logic              out1_valid,
    input logic              out0_over,
    input logic              out1_over,
    input logic [ADDR_W-1:0] out0_start
);
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> empty && !full && !out0_valid && !out1_valid);

    p_head_hold_r2: assert property (@(posedge clk) disable iff (rst)
        out0_valid && !take0 && !flush |=> out0_valid && $stable(out0_start));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        full && !take0 && !flush |=> full);

    p_empty_head_r4: assert property (@(posedge clk) disable iff (rst)
        empty |-> !out0_valid && !full);

    p_pair_rule_r5: assert property (@(posedge clk) disable iff (rst)
        out1_valid |-> out0_valid && !out0_over && !out1_over);

    p_flush_clear_r8: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

    p_full_swap_r9: assert property (@(posedge clk) disable iff (rst)
        full && push_valid && take0 && !(take1 && out1_valid) && !flush |=> full);

    p_empty_fill_r10: assert property (@(posedge clk) disable iff (rst)
        empty && push_valid && !flush |=> !empty && !out1_valid);
endmodule

bind fetch_target_queue fq_checker #(.ADDR_W(ADDR_W)) u_fq_checker (
    .clk(clk), .rst(rst), .flush(flush), .push_valid(push_valid),
    .take0(take0), .take1(take1), .full(full), .empty(empty),
    .out0_valid(out0_valid), .out1_valid(out1_valid),
    .out0_over(out0_over), .out1_over(out1_over), .out0_start(out0_start)
);

// File: tb/fetch_target_queue_bench.sv
module fetch_target_queue_bench;
    localparam int DEPTH = 4;
    localparam int AW    = 16;
    localparam int OW    = 4;
    localparam int DW    = AW + OW + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0, push_valid = 1'b0, push_over = 1'b0;
    logic take0 = 1'b0, take1 = 1'b0;
    logic [AW-1:0] push_start = '0;
    logic [OW-1:0] push_off = '0;
    logic full, empty, out0_valid, out1_valid, out0_over, out1_over;
    logic [AW-1:0] out0_start, out1_start;
    logic [OW-1:0] out0_off, out1_off;

    int checks = 0;
    int errors = 0;
    int seq_id = 1;
    logic [DW-1:0] mq[$];

    always #4 clk = ~clk;

    fetch_target_queue #(.ADDR_W(AW), .OFF_W(OW), .DEPTH(DEPTH)) u_fetch_target_queue (
        .clk(clk), .rst(rst), .flush(flush), .push_valid(push_valid),
        .push_start(push_start), .push_off(push_off), .push_over(push_over),
        .full(full), .take0(take0), .take1(take1),
        .out0_valid(out0_valid), .out0_start(out0_start), .out0_off(out0_off),
        .out0_over(out0_over), .out1_valid(out1_valid), .out1_start(out1_start),
        .out1_off(out1_off), .out1_over(out1_over), .empty(empty)
    );

    task automatic chk(input bit ok, input string req, input string sc,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s [%s] actual=%h expected=%h", req, sc, act, exp);
        end
    endtask

    task automatic check_outputs(input string sc);
        int  sz;
        bit  e1;
        sz = mq.size();
        chk(empty === (sz == 0), "R4", sc, 32'(empty), 32'(sz == 0));
        chk(full === (sz == DEPTH), "R3", sc, 32'(full), 32'(sz == DEPTH));
        chk(out0_valid === (sz > 0), "R2", sc, 32'(out0_valid), 32'(sz > 0));
        if (sz > 0)
            chk({out0_start, out0_off, out0_over} === mq[0], "R2", sc,
                32'({out0_start, out0_off, out0_over}), 32'(mq[0]));
        e1 = (sz >= 2) && !mq[0][0] && !mq[1][0];
        chk(out1_valid === e1, "R5", sc, 32'(out1_valid), 32'(e1));
        if (e1)
            chk({out1_start, out1_off, out1_over} === mq[1], "R5", sc,
                32'({out1_start, out1_off, out1_over}), 32'(mq[1]));
    endtask

    // One cycle: drive at the falling edge, check state, then model the rising edge.
    task automatic step(input bit pv, input bit ov, input bit t0, input bit t1,
                        input bit fl, input string sc);
        logic [DW-1:0] d;
        int n;
        bit pok;
        @(negedge clk);
        d = {AW'(seq_id * 37 + 5), OW'(seq_id), ov};
        push_valid = pv;
        push_start = d[DW-1:OW+1];
        push_off   = d[OW:1];
        push_over  = d[0];
        take0 = t0;
        take1 = t1;
        flush = fl;
        #1;
        check_outputs(sc);
        pok = (mq.size() >= 2) && !mq[0][0] && !mq[1][0];
        if (fl) mq.delete();
        else begin
            n = (t0 && mq.size() > 0) ? ((t1 && pok) ? 2 : 1) : 0;
            repeat (n) void'(mq.pop_front());
            if (pv && mq.size() < DEPTH) mq.push_back(d);
        end
        seq_id++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(empty === 1'b1, "R1", "reset", 32'(empty), 1);
        chk(full === 1'b0, "R1", "reset", 32'(full), 0);
        chk(out0_valid === 1'b0, "R1", "reset", 32'(out0_valid), 0);
        chk(out1_valid === 1'b0, "R1", "reset", 32'(out1_valid), 0);
        rst = 1'b0;

        // R3: fill, push into full without pop, then drain singly (R2).
        for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 0, 0, 0, "R3 fill");
        for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 1, 0, 0, "R2 drain");
        // R4: pops on empty are ignored.
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, "R4 empty pop");
        // R6: dual pops of normal blocks.
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, 0, "R6 load");
        for (int i = 0; i < 3; i++) step(0, 0, 1, 1, 0, "R6 dual");
        // R7: oversize blocks interleaved, consumer always asks for two.
        step(1, 1, 0, 0, 0, "R7 load");
        step(1, 0, 0, 0, 0, "R7 load");
        step(1, 0, 0, 0, 0, "R7 load");
        step(1, 1, 0, 0, 0, "R7 load");
        for (int i = 0; i < 5; i++) step(0, 0, 1, 1, 0, "R7 drain");
        // R8: flush with a simultaneous push and pop.
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R8 load");
        step(1, 0, 1, 0, 1, "R8 flush");
        step(0, 0, 0, 0, 0, "R8 after");
        // R9 and R11: push with single and dual pop at full.
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, 0, "R9 load");
        step(1, 0, 1, 0, 0, "R9 swap");
        step(1, 0, 1, 0, 0, "R9 swap");
        step(1, 0, 1, 1, 0, "R11 dual swap");
        step(0, 0, 0, 0, 0, "R11 after");
        step(0, 0, 0, 0, 1, "R8 clear");
        // R10: push with pop at empty.
        step(1, 0, 1, 1, 0, "R10 fill");
        step(0, 0, 0, 0, 0, "R10 after");
        // Sweep over every mix of controls.
        for (int i = 0; i < 4000; i++)
            step(($urandom % 4) != 0, ($urandom % 3) == 0, ($urandom % 3) != 0,
                 ($urandom % 2) == 1, ($urandom % 24) == 0, "sweep");
        step(0, 0, 0, 0, 0, "final");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule